// File: doc/BRIEF.md
# Bit-Matrix Product Unit

This unit reads each 64-bit operand as an 8x8 matrix of single bits. It multiplies the first matrix by the second over bits: each element product is a logical AND, and one of three reductions merges the eight products of a row-column pair. The reductions are parity (XOR), any-set (OR) and all-set (AND). The parity reduction also folds in an 8-bit constant vector, which gives an affine transform of the kind used in byte-wise substitution boxes, erasure codes and bit shuffles. A fourth operation returns only the transpose of the first matrix.

The datapath is purely combinational. One register stage captures the result on the clock edge where the input strobe is high, so a result appears one cycle after each accepted operation. The matrix dimension is a parameter, and the operand, constant and result widths follow from it.

Top module: `bmm_unit`

## Requirements
- R1: Byte k of an operand, bits [8k+7:8k], is matrix row k, and bit c inside that byte is column c. Result bit i belongs to result row i/8 and result column i%8.
- R2: With op_sel = 0 (affine parity), result bit i is the XOR of the eight bits of (row i/8 of mat_a AND column i%8 of mat_b), XORed with bit i%8 of affine.
- R3: With op_sel = 0 and affine = 0xFF, every result bit is the inverse of the plain parity from R2. This is the fixed constant that a register-only form of the operation uses.
- R4: With op_sel = 1 (any-set), result bit i is 1 exactly when (row i/8 of mat_a AND column i%8 of mat_b) is nonzero.
- R5: With op_sel = 2 (all-set), result bit i is 1 only when (row i/8 of mat_a AND column i%8 of mat_b) equals 0xFF.
- R6: With op_sel = 3 (transpose), result byte j bit k equals mat_a byte k bit j, and mat_b and affine have no effect on the result.
- R7: Column c of mat_b is formed from bit c of each byte of mat_b, taken in byte order: byte k supplies element k of the column.
- R8: When in_valid is high at a rising edge, out_valid is high after that edge and out_data holds the result for the inputs sampled at that edge.
- R9: When in_valid is low at a rising edge, out_valid is low after that edge and out_data keeps its previous value.
- R10: While rst_n is low, out_valid and out_data are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe; inputs are sampled when high |
| op_sel | input | 2 | 0 affine parity, 1 any-set, 2 all-set, 3 transpose of mat_a |
| mat_a | input | 64 | First matrix, byte k is row k |
| mat_b | input | 64 | Second matrix, byte k is row k |
| affine | input | 8 | Constant vector XORed into each result row in mode 0 |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_data | output | 64 | Registered result matrix |

## Verification
With random operands, the all-set reduction almost never returns a 1, because a 1 needs a full row of mat_a and a full column of mat_b to meet. The stimulus therefore uses directed matrices that make a hit certain and cases that miss by a single cleared bit. The bench then mixes dense operands into the random run so that the corner is reached again under varied operations. Transpose mode is driven with changing mat_b and affine values so that any leak of those inputs into the result shows up at the output.

// File: rtl/bmm_pkg.sv
package bmm_pkg;

   localparam int unsigned BMM_DIM_DEFAULT = 8;

   typedef enum logic [1:0] {
      BMM_OP_AFFINE = 2'd0,
      BMM_OP_ANY    = 2'd1,
      BMM_OP_ALL    = 2'd2,
      BMM_OP_FLIP   = 2'd3
   } bmm_op_e;

endpackage

// File: rtl/bmm_transpose.sv
module bmm_transpose #(
   parameter int unsigned DIM = bmm_pkg::BMM_DIM_DEFAULT
) (
   input  logic [DIM*DIM-1:0] src,
   output logic [DIM*DIM-1:0] dst
);
   localparam int unsigned NBITS = DIM * DIM;

   if (DIM < 2) begin : g_bad_dim
      $error("bmm_transpose: DIM must be at least 2");
   end

   // element (row j, col k) of dst comes from element (row k, col j) of src
   for (genvar j = 0; j < DIM; j++) begin : g_row
      for (genvar k = 0; k < DIM; k++) begin : g_col
         assign dst[j*DIM + k] = src[k*DIM + j];
      end
   end

   // a transpose only moves bits, so the number of ones is unchanged
   always_comb begin
      assert_flip_keeps_ones_R6: assert ($countones(dst) == $countones(src))
         else $error("transpose changed the population count");
   end

endmodule

// File: rtl/bmm_reduce.sv
module bmm_reduce #(
   parameter int unsigned DIM = bmm_pkg::BMM_DIM_DEFAULT
) (
   input  logic [DIM*DIM-1:0] row_src,
   input  logic [DIM*DIM-1:0] col_src,
   input  logic [DIM-1:0]     konst,
   output logic [DIM*DIM-1:0] par_vec,
   output logic [DIM*DIM-1:0] any_vec,
   output logic [DIM*DIM-1:0] all_vec
);
   localparam int unsigned NBITS = DIM * DIM;

   if (DIM < 2) begin : g_bad_dim
      $error("bmm_reduce: DIM must be at least 2");
   end

   // col_src holds the second matrix already transposed: byte c is column c
   for (genvar r = 0; r < DIM; r++) begin : g_r
      for (genvar c = 0; c < DIM; c++) begin : g_c
         logic [DIM-1:0] prod;
         assign prod              = row_src[r*DIM +: DIM] & col_src[c*DIM +: DIM];
         assign par_vec[r*DIM+c]  = (^prod) ^ konst[c];
         assign any_vec[r*DIM+c]  = |prod;
         assign all_vec[r*DIM+c]  = &prod;
      end
   end

   // an all-set hit is always also an any-set hit
   always_comb begin
      assert_all_within_any_R5: assert ((all_vec & ~any_vec) == '0)
         else $error("all-set bit without any-set bit");
   end

endmodule

// File: rtl/bmm_unit.sv
module bmm_unit #(
   parameter int unsigned DIM   = bmm_pkg::BMM_DIM_DEFAULT,
   parameter int unsigned NBITS = DIM * DIM
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [1:0]       op_sel,
   input  logic [NBITS-1:0] mat_a,
   input  logic [NBITS-1:0] mat_b,
   input  logic [DIM-1:0]   affine,
   output logic             out_valid,
   output logic [NBITS-1:0] out_data
);
   import bmm_pkg::*;

   if (NBITS != DIM * DIM) begin : g_bad_width
      $error("bmm_unit: NBITS must equal DIM*DIM");
   end

   logic [NBITS-1:0] b_cols;
   logic [NBITS-1:0] a_flip;
   logic [NBITS-1:0] par_vec, any_vec, all_vec;
   logic [NBITS-1:0] res_nxt;
   bmm_op_e          op;

   assign op = bmm_op_e'(op_sel);

   bmm_transpose #(.DIM(DIM)) u_tr_b (.src(mat_b), .dst(b_cols));
   bmm_transpose #(.DIM(DIM)) u_tr_a (.src(mat_a), .dst(a_flip));

   bmm_reduce #(.DIM(DIM)) u_red (
      .row_src (mat_a),
      .col_src (b_cols),
      .konst   (affine),
      .par_vec (par_vec),
      .any_vec (any_vec),
      .all_vec (all_vec)
   );

   always_comb begin
      unique case (op)
         BMM_OP_AFFINE: res_nxt = par_vec;
         BMM_OP_ANY:    res_nxt = any_vec;
         BMM_OP_ALL:    res_nxt = all_vec;
         default:       res_nxt = a_flip;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= res_nxt;
      end
   end

   assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid)
      else $error("out_valid missing after strobe");

   assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_data)))
      else $error("output changed without strobe");

endmodule

// File: tb/bmm_unit_tb.sv
`timescale 1ns/1ps
module bmm_unit_tb;
   logic        clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  op_sel = 2'd0;
   logic [63:0] mat_a = '0;
   logic [63:0] mat_b = '0;
   logic [7:0]  affine = '0;
   logic        out_valid;
   logic [63:0] out_data;

   int    n_chk = 0;
   int    n_bad = 0;
   bit    done = 0;
   logic        exp_v = 1'b0;
   logic [63:0] exp_d = '0;
   string       exp_tag = "R10";

   bmm_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
      .mat_a(mat_a), .mat_b(mat_b), .affine(affine),
      .out_valid(out_valid), .out_data(out_data)
   );

   // behavioural model written from the requirements
   function automatic logic [63:0] model(input logic [1:0] op, input logic [63:0] a,
                                         input logic [63:0] b, input logic [7:0] k);
      logic [63:0] res = '0;
      for (int i = 0; i < 64; i++) begin
         int r = i / 8;
         int c = i % 8;
         int ones = 0;
         for (int e = 0; e < 8; e++)
            if (a[8*r + e] && b[8*e + c]) ones++;
         case (op)
            2'd0: res[i] = ((ones % 2) == 1) ^ k[c];
            2'd1: res[i] = (ones != 0);
            2'd2: res[i] = (ones == 8);
            default: res[i] = a[8*c + r];
         endcase
      end
      return res;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input logic v, input logic [1:0] op, input logic [63:0] a,
                       input logic [63:0] b, input logic [7:0] k, input string tag);
      @(negedge clk);
      check({exp_tag, " valid"}, {63'd0, out_valid}, {63'd0, exp_v});
      check({exp_tag, " data"}, out_data, exp_d);
      in_valid = v; op_sel = op; mat_a = a; mat_b = b; affine = k;
      exp_v = v;
      if (v) exp_d = model(op, a, b, k);
      exp_tag = tag;
   endtask

   function automatic logic [63:0] rnd64();
      return {$urandom, $urandom};
   endfunction

   localparam logic [63:0] IDENT = 64'h8040201008040201;

   initial begin
      repeat (3) @(negedge clk);
      check("R10 reset valid", {63'd0, out_valid}, 64'd0);
      check("R10 reset data", out_data, 64'd0);
      rst_n = 1'b1;

      // R1 R7: identity times B returns B; B times identity returns B
      step(1, 2'd0, IDENT, 64'h0123456789ABCDEF, 8'h00, "R1 R7 identity-left");
      step(1, 2'd0, 64'hFEDCBA9876543210, IDENT, 8'h00, "R1 R7 identity-right");
      // R2 affine with arbitrary constant
      step(1, 2'd0, 64'hDEADBEEFCAFEF00D, 64'h1357924680ACE0F1, 8'h5A, "R2 affine");
      // R3 constant 0xFF
      step(1, 2'd0, 64'hDEADBEEFCAFEF00D, 64'h1357924680ACE0F1, 8'hFF, "R3 const-ff");
      step(1, 2'd0, 64'h0, 64'h0, 8'hFF, "R3 zero-operands");
      // R4 any-set
      step(1, 2'd1, 64'h0000000100000080, 64'h8000000000000001, 8'h00, "R4 any-sparse");
      step(1, 2'd1, 64'hA5A5A5A5A5A5A5A5, 64'h00FF00FF00FF00FF, 8'h33, "R4 any-stripe");
      // R5 all-set hit and near miss
      step(1, 2'd2, 64'hFF00000000000000, 64'h8080808080808080, 8'h00, "R5 all-hit");
      step(1, 2'd2, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 8'h00, "R5 all-full");
      step(1, 2'd2, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFF7F, 8'h00, "R5 all-miss-one");
      // R6 transpose, mat_b and affine varied to show they are ignored
      step(1, 2'd3, 64'h0123456789ABCDEF, 64'h0, 8'h00, "R6 flip");
      step(1, 2'd3, 64'h0123456789ABCDEF, 64'hFFFFFFFFFFFFFFFF, 8'hFF, "R6 flip-ignores-b-k");
      // R9 idle cycles with changing inputs
      step(0, 2'd1, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 8'hAA, "R9 idle");
      step(0, 2'd0, 64'h1111111111111111, 64'h2222222222222222, 8'h55, "R9 idle2");
      // R8 back-to-back and random mix, with dense operands for R5
      for (int n = 0; n < 300; n++) begin
         logic [63:0] a = rnd64();
         logic [63:0] b = rnd64();
         if (n % 4 == 0) begin a = a | rnd64() | rnd64(); b = b | rnd64() | rnd64(); end
         step(($urandom % 5) != 0, 2'($urandom), a, b, 8'($urandom), "R8 random");
      end
      step(0, 2'd0, 64'h0, 64'h0, 8'h0, "R9 tail");
      step(0, 2'd0, 64'h0, 64'h0, 8'h0, "R9 tail2");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule